// File: doc/BRIEF.md
# Ganged Hub Port Power and Overcurrent Controller

This block owns the single power-switch enable shared by every downstream port of a hub, watches one global overcurrent pin, and drives a user-visible status indicator. Host requests arrive already decoded as one-cycle per-port masks (power on, power off) and a strobe that acknowledges the hub overcurrent change. A level input tells the block that the hub is enumerated, and another that the hub is suspended.

The block keeps one request bit per port. The switch enable is high while any bit is set. A filtered overcurrent clears every bit at once, raises the hub overcurrent status and change bits, and makes the indicator blink. The blinking continues until the host has asked to power off every port or the hub is enumerated again. The overcurrent pin passes through a synchronizer and a persistence filter before the block acts on it.

Top module: `hubpwr_ctrl`

## Requirements
- R1: After a synchronous reset, `pwr_en`, `oc_status`, `oc_change` and `stat_out` are all 0 and no port holds a power request.
- R2: A 1 in bit i of `set_pwr_mask` records a power request for port i, and `pwr_en` is 1 after the next rising clock edge. `pwr_en` never rises without a set request in the cycle before.
- R3: `pwr_en` stays 1 while any port holds a request. It falls only after bits in `clr_pwr_mask` have removed every held request. When one port is both set and cleared in the same cycle, the clear wins.
- R4: `oc_n` is active low and goes through a two-flop synchronizer. It must then differ from the filtered level for FILT_CYCLES consecutive clocks before it takes effect. With FILT_CYCLES=4, a low pulse of 3 clocks has no effect, and a held low changes `oc_status` on the 6th rising edge after the pin changes.
- R5: On the edge where a filtered overcurrent begins, `oc_status` and `oc_change` become 1 and `pwr_en` becomes 0 together, and all port requests are discarded.
- R6: `oc_status` follows the filtered pin level in both directions.
- R7: `oc_change` stays 1 until `clr_oc_chg` is pulsed. If a new overcurrent begins in the same cycle as the pulse, the set wins.
- R8: While `oc_status` is 1, set requests are ignored and `pwr_en` stays 0.
- R9: When no blink is in progress, `stat_out` equals `enumerated`, delayed by one clock. `suspend` forces `stat_out` to 0 from the next edge.
- R10: From the start of an overcurrent, `stat_out` is a square wave that starts low. Each level lasts BLINK_HALF clocks.
- R11: The blink ends once, since the overcurrent began, the clear masks together have covered all NPORT ports, or when `enumerated` rises. After that, `stat_out` again follows `enumerated`. Clears that cover only some ports leave the blink running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_pwr_mask | input | NPORT | One-cycle power-on request, one bit per port |
| clr_pwr_mask | input | NPORT | One-cycle power-off request, one bit per port |
| clr_oc_chg | input | 1 | One-cycle acknowledge of the hub overcurrent change bit |
| enumerated | input | 1 | Hub is enumerated and configured |
| suspend | input | 1 | Hub is suspended |
| oc_n | input | 1 | Asynchronous overcurrent pin, low means overcurrent |
| pwr_en | output | 1 | Ganged port power-switch enable |
| oc_status | output | 1 | Hub overcurrent status bit (filtered) |
| oc_change | output | 1 | Hub overcurrent change bit |
| stat_out | output | 1 | Status indicator pin, steady or blinking |

## Verification
The assertions check these rules on every cycle: the enable never rises without a set request, it never falls without a clear or an overcurrent, it is held off for as long as the overcurrent status is high, the change bit holds until acknowledged, and suspend darkens the indicator. The bench scenarios are needed for the rest. These are the exact filter latency, the rejection of a short glitch, and the square-wave duty of the blink. They also cover the blink ending only when the cumulative clears reach every port or the hub is enumerated again.

// File: rtl/hubpwr_pkg.sv
package hubpwr_pkg;
  typedef enum logic {
    IND_STEADY = 1'b0,
    IND_BLINK  = 1'b1
  } ind_mode_t;

  function automatic int unsigned cnt_width(input int unsigned limit);
    return (limit > 1) ? $clog2(limit) : 1;
  endfunction
endpackage

// File: rtl/hubpwr_ocfilt.sv
module hubpwr_ocfilt #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic oc_n,
  output logic oc_act,
  output logic oc_rise
);
  localparam int unsigned CW = hubpwr_pkg::cnt_width(FILT_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(FILT_CYCLES - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   filt_n_q;
  logic [CW-1:0]          cnt_q;
  logic                   synced_n;
  logic                   mism;
  logic                   hit;

  assign synced_n = sync_q[SYNC_STAGES-1];
  assign mism     = (synced_n != filt_n_q);
  assign hit      = mism && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q   <= '1;
      filt_n_q <= 1'b1;
      cnt_q    <= '0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], oc_n};
      if (hit) begin
        filt_n_q <= synced_n;
        cnt_q    <= '0;
      end else if (mism) begin
        cnt_q <= cnt_q + 1'b1;
      end else begin
        cnt_q <= '0;
      end
    end
  end

  assign oc_act  = ~filt_n_q;
  assign oc_rise = hit & ~synced_n;
endmodule

// File: rtl/hubpwr_map.sv
module hubpwr_map #(
  parameter int unsigned NPORT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPORT-1:0] set_mask,
  input  logic [NPORT-1:0] clr_mask,
  input  logic             oc_act,
  input  logic             oc_rise,
  output logic             pwr_en
);
  logic [NPORT-1:0] map_q;
  logic [NPORT-1:0] map_d;
  logic [NPORT-1:0] set_eff;

  always_comb begin
    set_eff = oc_act ? '0 : set_mask;
    if (oc_rise) map_d = '0;
    else         map_d = (map_q | set_eff) & ~clr_mask;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      map_q  <= '0;
      pwr_en <= 1'b0;
    end else begin
      map_q  <= map_d;
      pwr_en <= |map_d;
    end
  end
endmodule

// File: rtl/hubpwr_ind.sv
module hubpwr_ind #(
  parameter int unsigned NPORT      = 4,
  parameter int unsigned BLINK_HALF = 3000000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enumerated,
  input  logic             suspend,
  input  logic [NPORT-1:0] clr_mask,
  input  logic             oc_rise,
  output logic             stat_out
);
  import hubpwr_pkg::*;
  localparam int unsigned BCW = cnt_width(BLINK_HALF);
  localparam logic [BCW-1:0] BLAST = BCW'(BLINK_HALF - 1);

  ind_mode_t        mode_q, mode_d;
  logic [NPORT-1:0] seen_q, seen_d;
  logic [BCW-1:0]   cnt_q, cnt_d;
  logic             phase_q, phase_d;
  logic             enum_q;
  logic             enum_rise;

  assign enum_rise = enumerated & ~enum_q;

  always_comb begin
    mode_d  = IND_STEADY;
    seen_d  = '0;
    cnt_d   = '0;
    phase_d = 1'b0;
    if (oc_rise) begin
      mode_d = IND_BLINK;
    end else if (mode_q == IND_BLINK) begin
      seen_d = seen_q | clr_mask;
      if (!(&seen_d) && !enum_rise) begin
        mode_d  = IND_BLINK;
        if (cnt_q == BLAST) begin
          cnt_d   = '0;
          phase_d = ~phase_q;
        end else begin
          cnt_d   = cnt_q + 1'b1;
          phase_d = phase_q;
        end
      end else begin
        seen_d = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= IND_STEADY;
      seen_q   <= '0;
      cnt_q    <= '0;
      phase_q  <= 1'b0;
      enum_q   <= 1'b0;
      stat_out <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      seen_q  <= seen_d;
      cnt_q   <= cnt_d;
      phase_q <= phase_d;
      enum_q  <= enumerated;
      if (suspend)                  stat_out <= 1'b0;
      else if (mode_d == IND_BLINK) stat_out <= phase_d;
      else                          stat_out <= enumerated;
    end
  end
endmodule

// File: rtl/hubpwr_ctrl.sv
module hubpwr_ctrl #(
  parameter int unsigned NPORT       = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_CYCLES = 16,
  parameter int unsigned BLINK_HALF  = 3000000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPORT-1:0] set_pwr_mask,
  input  logic [NPORT-1:0] clr_pwr_mask,
  input  logic             clr_oc_chg,
  input  logic             enumerated,
  input  logic             suspend,
  input  logic             oc_n,
  output logic             pwr_en,
  output logic             oc_status,
  output logic             oc_change,
  output logic             stat_out
);
  logic oc_act;
  logic oc_rise;

  hubpwr_ocfilt #(.SYNC_STAGES(SYNC_STAGES), .FILT_CYCLES(FILT_CYCLES)) filt_i (
    .clk(clk), .rst(rst), .oc_n(oc_n), .oc_act(oc_act), .oc_rise(oc_rise)
  );

  hubpwr_map #(.NPORT(NPORT)) map_i (
    .clk(clk), .rst(rst), .set_mask(set_pwr_mask), .clr_mask(clr_pwr_mask),
    .oc_act(oc_act), .oc_rise(oc_rise), .pwr_en(pwr_en)
  );

  hubpwr_ind #(.NPORT(NPORT), .BLINK_HALF(BLINK_HALF)) ind_i (
    .clk(clk), .rst(rst), .enumerated(enumerated), .suspend(suspend),
    .clr_mask(clr_pwr_mask), .oc_rise(oc_rise), .stat_out(stat_out)
  );

  assign oc_status = oc_act;

  always_ff @(posedge clk) begin
    if (rst)             oc_change <= 1'b0;
    else if (oc_rise)    oc_change <= 1'b1;
    else if (clr_oc_chg) oc_change <= 1'b0;
  end
endmodule

// File: rtl/hubpwr_ctrl_chk.sv
module hubpwr_ctrl_chk #(
  parameter int unsigned NPORT = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [NPORT-1:0] set_pwr_mask,
  input logic [NPORT-1:0] clr_pwr_mask,
  input logic             clr_oc_chg,
  input logic             enumerated,
  input logic             suspend,
  input logic             oc_n,
  input logic             pwr_en,
  input logic             oc_status,
  input logic             oc_change,
  input logic             stat_out
);
  a_r2_rise_needs_set: assert property (@(posedge clk) disable iff (rst)
    $rose(pwr_en) |-> $past(|set_pwr_mask));

  a_r3_fall_has_cause: assert property (@(posedge clk) disable iff (rst)
    $fell(pwr_en) |-> ($past(|clr_pwr_mask) || oc_status));

  a_r5_entry_drops_pwr: assert property (@(posedge clk) disable iff (rst)
    $rose(oc_status) |-> (!pwr_en && oc_change));

  a_r6_status_from_pin: assert property (@(posedge clk) disable iff (rst)
    $rose(oc_status) |-> !$past(oc_n, 2));

  a_r8_no_pwr_in_oc: assert property (@(posedge clk) disable iff (rst)
    oc_status |-> !pwr_en);

  a_r7_chg_sticky: assert property (@(posedge clk) disable iff (rst)
    (oc_change && !clr_oc_chg) |=> oc_change);

  a_r7_chg_clears: assert property (@(posedge clk) disable iff (rst)
    clr_oc_chg |=> (!oc_change || $rose(oc_status)));

  a_r9_suspend_dark: assert property (@(posedge clk) disable iff (rst)
    suspend |=> !stat_out);
endmodule

bind hubpwr_ctrl hubpwr_ctrl_chk #(.NPORT(NPORT)) chk_i (
  .clk(clk), .rst(rst), .set_pwr_mask(set_pwr_mask), .clr_pwr_mask(clr_pwr_mask),
  .clr_oc_chg(clr_oc_chg), .enumerated(enumerated), .suspend(suspend), .oc_n(oc_n),
  .pwr_en(pwr_en), .oc_status(oc_status), .oc_change(oc_change), .stat_out(stat_out)
);

// File: tb/hubpwr_ctrl_tb_top.sv
module hubpwr_ctrl_tb_top;
  localparam int NP = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NP-1:0] set_m = '0;
  logic [NP-1:0] clr_m = '0;
  logic          clr_chg = 1'b0;
  logic          en = 1'b0;
  logic          su = 1'b0;
  logic          oc_n = 1'b1;
  logic          pwr_en, oc_status, oc_change, stat_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  hubpwr_ctrl #(.NPORT(NP), .SYNC_STAGES(2), .FILT_CYCLES(4), .BLINK_HALF(5)) dut_i (
    .clk(clk), .rst(rst), .set_pwr_mask(set_m), .clr_pwr_mask(clr_m),
    .clr_oc_chg(clr_chg), .enumerated(en), .suspend(su), .oc_n(oc_n),
    .pwr_en(pwr_en), .oc_status(oc_status), .oc_change(oc_change), .stat_out(stat_out)
  );

  // vector fields: set[11:8] clr[7:4] en[3] su[2] exp_pwr[1] exp_stat[0]
  localparam logic [11:0] VEC [0:8] = '{
    12'b0001_0000_0_0_1_0,
    12'b0100_0000_0_0_1_0,
    12'b0000_0001_0_0_1_0,
    12'b0000_0100_0_0_0_0,
    12'b1000_1000_0_0_0_0,
    12'b0010_0000_1_0_1_1,
    12'b0000_0000_1_1_1_0,
    12'b0000_1111_1_0_0_1,
    12'b0000_0000_0_0_0_0
  };

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic count_high(input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      tick();
      if (stat_out) hi++;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    int hi;
    ticks(3);
    rst = 1'b0;
    tick();
    chk("R1 pwr_en after reset", pwr_en, 0);
    chk("R1 oc_status after reset", oc_status, 0);
    chk("R1 oc_change after reset", oc_change, 0);
    chk("R1 stat_out after reset", stat_out, 0);

    for (int v = 0; v < 9; v++) begin
      set_m = VEC[v][11:8];
      clr_m = VEC[v][7:4];
      en    = VEC[v][3];
      su    = VEC[v][2];
      tick();
      set_m = '0;
      clr_m = '0;
      ticks(2);
      chk($sformatf("R2 R3 pwr_en vector %0d", v), pwr_en, int'(VEC[v][1]));
      chk($sformatf("R9 stat_out vector %0d", v), stat_out, int'(VEC[v][0]));
    end

    // R4: a 3-clock glitch is rejected
    set_m = 4'b0001; tick(); set_m = '0; tick();
    oc_n = 1'b0; ticks(3); oc_n = 1'b1; ticks(10);
    chk("R4 glitch oc_status", oc_status, 0);
    chk("R4 glitch oc_change", oc_change, 0);
    chk("R4 glitch pwr_en", pwr_en, 1);

    // R4/R5/R10: held overcurrent, exact latency
    en = 1'b1; ticks(2);
    oc_n = 1'b0; ticks(5);
    chk("R4 oc_status before 6th edge", oc_status, 0);
    chk("R4 pwr_en before 6th edge", pwr_en, 1);
    tick();
    chk("R5 oc_status at entry", oc_status, 1);
    chk("R5 oc_change at entry", oc_change, 1);
    chk("R5 pwr_en at entry", pwr_en, 0);
    chk("R10 blink starts low", stat_out, 0);
    count_high(20, hi);
    chk("R10 blink duty high count", hi, 10);

    // R8: set ignored during overcurrent
    set_m = 4'b1111; tick(); set_m = '0; ticks(2);
    chk("R8 pwr_en stays off", pwr_en, 0);

    // R7: acknowledge the change bit
    clr_chg = 1'b1; tick(); clr_chg = 1'b0; tick();
    chk("R7 oc_change cleared", oc_change, 0);
    chk("R6 oc_status still set", oc_status, 1);

    // R6: recovery
    oc_n = 1'b1; ticks(10);
    chk("R6 oc_status follows pin", oc_status, 0);
    chk("R7 oc_change stays clear", oc_change, 0);

    // R11: partial clears keep blinking, full coverage ends it
    clr_m = 4'b0011; tick(); clr_m = '0;
    count_high(20, hi);
    chk("R11 partial clear still blinking", hi, 10);
    clr_m = 4'b1100; tick(); clr_m = '0; ticks(2);
    count_high(12, hi);
    chk("R11 steady after all ports cleared", hi, 12);

    // R11: re-enumeration ends blinking
    oc_n = 1'b0; ticks(10); oc_n = 1'b1;
    chk("R5 oc_change set again", oc_change, 1);
    count_high(20, hi);
    chk("R10 second blink duty", hi, 10);
    en = 1'b0; ticks(2); en = 1'b1; ticks(2);
    count_high(12, hi);
    chk("R11 steady after re-enumeration", hi, 12);

    finish_run();
  end
endmodule